// File: doc/BRIEF.md
# Symmetric Odd-Ratio Clock Divider

This block takes a reference clock and produces a square wave at one fifth of its frequency. The high time and the low time are each exactly two and a half reference periods. The ratio is set by a parameter and must be odd and at least three; the default is five. A modulo counter runs on the rising edge. One decode of the counter toggles a rising-edge register. A second decode is retimed by half a reference period and toggles a falling-edge register. The divided output is the exclusive-OR of the two registers, so no derived signal is ever used as a clock.

The merged train of both decodes is brought out as a debug event at twice the output rate. An active-low synchronous reset starts the sequence from a known phase. An enable input stalls the whole divider while it is low.

Top module: `sdiv_symmetric`

## Requirements
- R1: With enable held high, the period of `clk_div` is exactly RATIO reference periods (50 ns for RATIO = 5 at 10 ns).
- R2: In free run, every high time and every low time of `clk_div` is exactly RATIO/2 reference periods (25 ns for the default).
- R3: After reset is released, `clk_div` rises at the falling reference edge that follows the first enabled rising edge, which is half a reference period later. The first high time is complete (25 ns).
- R4: Let n be the number of enabled rising edges since reset. For RATIO = 5, `clk_div` sampled just after a falling reference edge is 1 exactly when n mod 5 is 1, 2 or 3, and 0 otherwise.
- R5: While `rst_n` is 0 at a rising edge, the divider is cleared. After the following falling edge, `clk_div` and `dbl_evt` both read 0.
- R6: While `en` is 0, the counter and both toggle registers hold. `clk_div` keeps the level given by R4 for the unchanged n. A falling-edge transition already due from the last enabled rising edge still completes.
- R7: `dbl_evt` is 1 for one reference period after each rising edge at which the count enters RATIO−1. It is also 1 for one reference period after the falling edge that follows entry into count (RATIO−3)/2. Sampled after a falling edge, it is 1 exactly when the last rising edge was enabled and n mod 5 is 1 or 4. In free run its rising edges are 2.5 reference periods apart.
- R8: A reset applied while `clk_div` is high brings it low and restarts the sequence of R4 from n = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; both edges are used |
| rst_n | input | 1 | Active-low reset, sampled synchronously on both edges |
| en | input | 1 | Advance enable; low stalls the divider |
| clk_div | output | 1 | Divided clock with 50% duty cycle |
| dbl_evt | output | 1 | Debug event train at twice the output rate |

## Verification
The hardest case is enable falling right after the counter has entered the falling-edge tap. The retimed toggle is then still pending half a period later, and it must fire exactly once, whether the stall is short or long. The stimulus table stops and restarts the divider at every counter phase, with stalls of one to four cycles. Each sample is compared with a level model driven only by the count of enabled edges. Edge-time measurements over twenty free-running periods then confirm the exact half-period symmetry.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;

  // Count value whose entry toggles the rising-edge register.
  function automatic int hi_tap(input int ratio);
    return ratio - 1;
  endfunction

  // Count value whose entry arms the falling-edge toggle, half a period later.
  function automatic int lo_tap(input int ratio);
    return (ratio - 3) / 2;
  endfunction

  function automatic bit ratio_ok(input int ratio);
    return (ratio >= 3) && (ratio % 2 == 1);
  endfunction

endpackage

// File: rtl/sdiv_counter.sv
`timescale 1ns/1ps
module sdiv_counter #(
  parameter int RATIO = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  output logic [$clog2(RATIO)-1:0]     cnt,
  output logic                         enter_lo,
  output logic                         enter_hi
);
  localparam int W = $clog2(RATIO);
  localparam logic [W-1:0] LAST = W'(RATIO - 1);
  localparam logic [W-1:0] LO_V = W'(sdiv_pkg::lo_tap(RATIO));
  localparam logic [W-1:0] HI_V = W'(sdiv_pkg::hi_tap(RATIO));

  logic [W-1:0] nxt;

  always_comb begin
    if (cnt == LAST) nxt = '0;
    else             nxt = cnt + W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= nxt;
  end

  assign enter_lo = en && (nxt == LO_V);
  assign enter_hi = en && (nxt == HI_V);

  // R1: the count wraps to zero after its last state
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == LAST) |=> (cnt == '0));

  // R6: a stalled counter keeps its value
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/sdiv_rise_stage.sv
`timescale 1ns/1ps
module sdiv_rise_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_lo,
  input  logic enter_hi,
  output logic tog_r,
  output logic hi_flag,
  output logic arm_lo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_r   <= 1'b0;
      hi_flag <= 1'b0;
      arm_lo  <= 1'b0;
    end else begin
      tog_r   <= tog_r ^ enter_hi;
      hi_flag <= enter_hi;
      arm_lo  <= enter_lo;
    end
  end

  // R4: the rising-edge register only moves on entry into the top count
  assert_rise_tog_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enter_hi |=> $stable(tog_r));

  // R7: the top-count event never lasts beyond one reference period
  assert_hi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_flag |=> !hi_flag);
endmodule

// File: rtl/sdiv_fall_stage.sv
`timescale 1ns/1ps
module sdiv_fall_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_lo,
  output logic tog_f,
  output logic lo_q
);
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      tog_f <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      tog_f <= tog_f ^ arm_lo;
      lo_q  <= arm_lo;
    end
  end

  // R3: the falling-edge register toggles only half a period after arming
  assert_fall_tog_R3: assert property (@(negedge clk) disable iff (!rst_n)
    !arm_lo |=> $stable(tog_f));

  // R6: each arming gives exactly one falling-edge toggle, even when stalled
  assert_single_fire_R6: assert property (@(negedge clk) disable iff (!rst_n)
    lo_q |=> !lo_q);
endmodule

// File: rtl/sdiv_symmetric.sv
`timescale 1ns/1ps
module sdiv_symmetric #(
  parameter int RATIO = 5
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic en,
  output logic clk_div,
  output logic dbl_evt
);
  localparam int W = $clog2(RATIO);

  if (!sdiv_pkg::ratio_ok(RATIO)) begin : g_bad_ratio
    $error("sdiv_symmetric: RATIO must be odd and at least 3");
  end

  logic [W-1:0] cnt;
  logic         enter_lo, enter_hi;
  logic         tog_r, hi_flag, arm_lo;
  logic         tog_f, lo_q;

  sdiv_counter #(.RATIO(RATIO)) u_cnt (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .en       (en),
    .cnt      (cnt),
    .enter_lo (enter_lo),
    .enter_hi (enter_hi)
  );

  sdiv_rise_stage u_rise (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .enter_lo (enter_lo),
    .enter_hi (enter_hi),
    .tog_r    (tog_r),
    .hi_flag  (hi_flag),
    .arm_lo   (arm_lo)
  );

  sdiv_fall_stage u_fall (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .arm_lo (arm_lo),
    .tog_f  (tog_f),
    .lo_q   (lo_q)
  );

  assign clk_div = tog_r ^ tog_f;
  assign dbl_evt = hi_flag | lo_q;

  // R7: the two merged decodes never overlap
  assert_evt_excl_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $onehot0({hi_flag, lo_q}));

  // R1: the count never leaves its modulo range
  assert_cnt_range_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt <= W'(RATIO - 1));
endmodule

// File: tb/tb_sdiv_symmetric.sv
`timescale 1ns/1ps
module tb_sdiv_symmetric;
  logic clk_ref = 1'b0;
  logic rst_n;
  logic en;
  logic clk_div, dbl_evt;

  int n_chk = 0;
  int n_bad = 0;
  int n_model = 0;
  bit adv = 1'b0;

  always #5 clk_ref = ~clk_ref;

  sdiv_symmetric #(.RATIO(5)) dut (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .en      (en),
    .clk_div (clk_div),
    .dbl_evt (dbl_evt)
  );

  // vector: [11] rst_n, [10] en, [9:0] repeat count
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b0, 10'd3},  {1'b1, 1'b1, 10'd12}, {1'b1, 1'b0, 10'd4},
    {1'b1, 1'b1, 10'd1},  {1'b1, 1'b0, 10'd3},  {1'b1, 1'b1, 10'd6},
    {1'b1, 1'b0, 10'd1},  {1'b1, 1'b1, 10'd2},  {1'b1, 1'b0, 10'd2},
    {1'b1, 1'b1, 10'd9},  {1'b0, 1'b1, 10'd2},  {1'b1, 1'b1, 10'd3},
    {1'b1, 1'b0, 10'd2},  {1'b1, 1'b1, 10'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one reference cycle: drive, pass the rising edge, sample after the falling edge
  task automatic tick(input logic r, input logic e);
    int m;
    bit lvl, evt;
    rst_n = r;
    en    = e;
    @(posedge clk_ref);
    if (!r) begin n_model = 0; adv = 1'b0; end
    else if (e) begin n_model++; adv = 1'b1; end
    else adv = 1'b0;
    #7;
    m   = n_model % 5;
    lvl = (m >= 1) && (m <= 3);
    evt = adv && (m == 1 || m == 4);
    if (!r) begin
      chk(clk_div == 1'b0, "R5 clk_div", int'(clk_div), 0);
      chk(dbl_evt == 1'b0, "R5 dbl_evt", int'(dbl_evt), 0);
    end else begin
      chk(clk_div == lvl, e ? "R4 level" : "R6 hold level", int'(clk_div), int'(lvl));
      chk(dbl_evt == evt, "R7 event", int'(dbl_evt), int'(evt));
    end
  endtask

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    realtime t_ref, t_a, t_b;
    rst_n = 1'b0;
    en    = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v][9:0]); k++) tick(VEC[v][11], VEC[v][10]);
    end

    // R5: reset state, then R3: first rise half a period after first enabled edge
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    rst_n = 1'b1;
    en    = 1'b1;
    @(posedge clk_ref);
    t_ref = $realtime;
    @(posedge clk_div);
    t_a = $realtime;
    chk(int'(t_a - t_ref) == 5, "R3 first rise delay", int'(t_a - t_ref), 5);
    @(negedge clk_div);
    t_b = $realtime;
    chk(int'(t_b - t_a) == 25, "R3 first high time", int'(t_b - t_a), 25);

    // R1, R2: twenty free-running periods
    @(posedge clk_div);
    t_ref = $realtime;
    for (int p = 0; p < 20; p++) begin
      @(negedge clk_div);
      t_a = $realtime;
      chk(int'(t_a - t_ref) == 25, "R2 high time", int'(t_a - t_ref), 25);
      @(posedge clk_div);
      t_b = $realtime;
      chk(int'(t_b - t_a) == 25, "R2 low time", int'(t_b - t_a), 25);
      chk(int'(t_b - t_ref) == 50, "R1 period", int'(t_b - t_ref), 50);
      t_ref = t_b;
    end

    // R7: double-rate event spacing
    @(posedge dbl_evt);
    t_ref = $realtime;
    for (int p = 0; p < 8; p++) begin
      @(posedge dbl_evt);
      t_a = $realtime;
      chk(int'(t_a - t_ref) == 25, "R7 event spacing", int'(t_a - t_ref), 25);
      t_ref = t_a;
    end

    // R8: reset while the output is high, then restart
    @(posedge clk_div);
    @(posedge clk_ref);
    #7;
    chk(clk_div == 1'b1, "R8 high before reset", int'(clk_div), 1);
    tick(1'b0, 1'b1);
    chk(clk_div == 1'b0, "R8 low after reset", int'(clk_div), 0);
    for (int k = 0; k < 11; k++) tick(1'b1, 1'b1);

    // R6: stall on every phase, including just after entering the falling tap
    for (int ph = 0; ph < 5; ph++) begin
      tick(1'b1, 1'b1);
      for (int k = 0; k < 3; k++) tick(1'b1, 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule